// File: doc/BRIEF.md
# Z80 Board I/O Glue

This block is the I/O decode and control glue for a small Z80 single-board computer. It watches the processor's I/O bus, which carries an 8-bit port address, the request, read, write and M1 strobes, and the write data. From these it produces three groups of outputs:

- chip selects and register-select lines for a four-channel counter/timer, a dual serial controller, a floppy controller and a spare user slot;
- the outputs of a 7-bit board control register, an 8-bit printer data latch and a printer strobe flip-flop;
- a memory overlay that decides, for each memory access, whether the boot ROM or DRAM answers.

The port decode is partial on purpose, so every local register answers at several aliased addresses. The serial controller takes its channel and data/control selects from A3 and A2. The printer strobe is set and cleared by writes to two ports, whatever the data. After reset a 4KB ROM appears eight times over the lower 32KB. One control bit replaces it with DRAM.

The block drives no read data. Reads of its own registers leave the bus to the peripherals.

Top module: `z80_io_glue`

## Requirements
- R1: The board control register is selected by any port address with bits 7..5 = 000 and bits 1..0 = 00, whatever bits 4..2 hold. A write there loads data bits 6..0. Reset clears it to zero, and a read of that port leaves it unchanged.
- R2: The printer data latch is written by any port with bits 7..5 = 000 and bits 1..0 = 01. It stores all 8 data bits and resets to zero.
- R3: The strobe flip-flop resets to 0. A write to any port with bits 7..5 = 000 and bits 1..0 = 10 sets it, and a write with bits 1..0 = 11 clears it, whatever the data value.
- R4: Port addresses with bits 7..6 = 01 assert `ctc_cs_o`, with `ctc_ch_o` = address bits 5..4. Channels 0 to 3 sit at 40h, 50h, 60h and 70h.
- R5: Port addresses with bits 7..6 = 10 assert `sio_cs_o`, with `sio_ch_o` = A3 (channel B when 1) and `sio_cd_o` = A2 (control when 1). This gives data A at 80h, control A at 84h, data B at 88h and control B at 8Ch.
- R6: Port addresses with bits 7..6 = 11 assert `fdc_cs_o`, with `fdc_rs_o` = A1..A0. `fdc_rd_o` is the select qualified by an active read, and `fdc_wr_o` is the select qualified by an active write.
- R7: Port addresses 30h–3Fh assert `user_cs_o`. Addresses 20h–2Fh assert no select and change no register.
- R8: An I/O request with M1 active is an interrupt acknowledge. It asserts no select and writes no register. All register-select outputs are 0 whenever their chip select is 0.
- R9: When control bit 6 is 0, a memory request below 8000h asserts `rom_cs_o` and not `dram_cs_o`. When the bit is 1, such a request asserts `dram_cs_o`. `rom_addr_o` is always memory address bits 11..0, so the ROM repeats every 4KB.
- R10: A memory request at 8000h or above always asserts `dram_cs_o` and never `rom_cs_o`. With no memory request, neither select is asserted.
- R11: The control register drives the following outputs:
  - bit 6 → `rom_dis_o`
  - bit 5 → `dden_dis_o`
  - bit 4 → `side1_o`
  - bits 3..0 → `drv_sel_o`

  Data bit 7 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_addr_i | input | 8 | Low byte of the address bus during I/O cycles |
| iorq_ni | input | 1 | I/O request, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| m1_ni | input | 1 | Opcode fetch / interrupt acknowledge marker, active low |
| data_i | input | 8 | Write data from the processor |
| mreq_ni | input | 1 | Memory request, active low |
| mem_addr_i | input | 16 | Memory address |
| ctc_cs_o | output | 1 | Counter/timer select |
| ctc_ch_o | output | 2 | Counter/timer channel |
| sio_cs_o | output | 1 | Serial controller select |
| sio_ch_o | output | 1 | Serial channel (1 = B) |
| sio_cd_o | output | 1 | Serial control/data (1 = control) |
| fdc_cs_o | output | 1 | Floppy controller select |
| fdc_rs_o | output | 2 | Floppy register select |
| fdc_rd_o | output | 1 | Floppy read strobe |
| fdc_wr_o | output | 1 | Floppy write strobe |
| user_cs_o | output | 1 | Spare user select |
| drv_sel_o | output | 4 | Drive selects |
| side1_o | output | 1 | Disk side 1 select |
| dden_dis_o | output | 1 | Double density disable |
| rom_dis_o | output | 1 | Boot ROM disabled |
| prn_data_o | output | 8 | Printer data latch |
| prn_strobe_o | output | 1 | Printer strobe flip-flop |
| rom_cs_o | output | 1 | Boot ROM select |
| rom_addr_o | output | 12 | Boot ROM address |
| dram_cs_o | output | 1 | DRAM select |

## Verification
The bench builds the block with its default parameters: an 8-bit port address, a 16-bit memory address, a 4KB ROM and a 32KB overlay window. These values make every one of the 256 port addresses reachable in read, write and interrupt-acknowledge sweeps. The sweeps cover each alias of the local registers and the reserved range. The defaults also put the 7FFFh/8000h window edge and the 4KB mirror boundaries within a short memory walk, which the bench runs with the ROM both enabled and disabled.

// File: rtl/z80_glue_pkg.sv
package z80_glue_pkg;
  localparam int CTRL_W      = 7;
  localparam int BIT_ROM_DIS = 6;
  localparam int BIT_DDEN    = 5;
  localparam int BIT_SIDE    = 4;
  localparam int DRV_W       = 4;

  typedef enum logic [3:0] {
    IO_NONE,
    IO_CTRL,
    IO_PDATA,
    IO_STB_SET,
    IO_STB_CLR,
    IO_CTC,
    IO_SIO,
    IO_FDC,
    IO_USER
  } io_class_e;
endpackage

// File: rtl/z80_io_decode.sv
module z80_io_decode
  import z80_glue_pkg::*;
#(
  parameter int IO_AW = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IO_AW-1:0] addr_i,
  input  logic             iorq_ni,
  input  logic             rd_ni,
  input  logic             wr_ni,
  input  logic             m1_ni,
  output io_class_e        class_o,
  output logic             reg_wr_o,
  output logic             ctc_cs_o,
  output logic [1:0]       ctc_ch_o,
  output logic             sio_cs_o,
  output logic             sio_ch_o,
  output logic             sio_cd_o,
  output logic             fdc_cs_o,
  output logic [1:0]       fdc_rs_o,
  output logic             fdc_rd_o,
  output logic             fdc_wr_o,
  output logic             user_cs_o
);
  localparam int TOP = IO_AW - 1;

  logic io_act;
  io_class_e cls;

  // M1 together with IORQ is an interrupt acknowledge: no decode
  assign io_act = !iorq_ni && m1_ni;

  always_comb begin
    cls = IO_NONE;
    if (io_act) begin
      unique case (addr_i[TOP -: 2])
        2'b01: cls = IO_CTC;
        2'b10: cls = IO_SIO;
        2'b11: cls = IO_FDC;
        default: begin
          if (!addr_i[TOP-2]) begin
            unique case (addr_i[1:0])
              2'b00: cls = IO_CTRL;
              2'b01: cls = IO_PDATA;
              2'b10: cls = IO_STB_SET;
              default: cls = IO_STB_CLR;
            endcase
          end else if (addr_i[TOP-3]) begin
            cls = IO_USER;
          end
        end
      endcase
    end
  end

  assign class_o   = cls;
  assign reg_wr_o  = io_act && !wr_ni;

  assign ctc_cs_o  = (cls == IO_CTC);
  assign ctc_ch_o  = ctc_cs_o ? addr_i[TOP-2 -: 2] : 2'b00;
  assign sio_cs_o  = (cls == IO_SIO);
  assign sio_ch_o  = sio_cs_o && addr_i[3];
  assign sio_cd_o  = sio_cs_o && addr_i[2];
  assign fdc_cs_o  = (cls == IO_FDC);
  assign fdc_rs_o  = fdc_cs_o ? addr_i[1:0] : 2'b00;
  assign fdc_rd_o  = fdc_cs_o && !rd_ni;
  assign fdc_wr_o  = fdc_cs_o && !wr_ni;
  assign user_cs_o = (cls == IO_USER);

  p_no_sel_inta_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!iorq_ni && !m1_ni) |-> !(ctc_cs_o || sio_cs_o || fdc_cs_o || user_cs_o));
  p_one_sel_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ctc_cs_o, sio_cs_o, fdc_cs_o, user_cs_o}));
  p_fdc_strobe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fdc_rd_o || fdc_wr_o) |-> (fdc_cs_o && !iorq_ni));
  p_no_sel_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iorq_ni |-> !(ctc_cs_o || sio_cs_o || fdc_cs_o || user_cs_o || reg_wr_o));
endmodule

// File: rtl/z80_board_regs.sv
module z80_board_regs
  import z80_glue_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  io_class_e         class_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] prn_data_o,
  output logic              prn_strobe_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [DATA_W-1:0] prn_q;
  logic              stb_q;
  logic              wr_ctrl, wr_prn, wr_set, wr_clr;

  assign wr_ctrl = reg_wr_i && (class_i == IO_CTRL);
  assign wr_prn  = reg_wr_i && (class_i == IO_PDATA);
  assign wr_set  = reg_wr_i && (class_i == IO_STB_SET);
  assign wr_clr  = reg_wr_i && (class_i == IO_STB_CLR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      prn_q  <= '0;
      stb_q  <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= data_i[CTRL_W-1:0];
      if (wr_prn)  prn_q  <= data_i;
      if (wr_set)      stb_q <= 1'b1;
      else if (wr_clr) stb_q <= 1'b0;
    end
  end

  assign ctrl_o       = ctrl_q;
  assign prn_data_o   = prn_q;
  assign prn_strobe_o = stb_q;

  p_ctrl_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ctrl |=> $stable(ctrl_o));
  p_prn_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_prn |=> $stable(prn_data_o));
  p_stb_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_set |=> prn_strobe_o);
  p_stb_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr |=> !prn_strobe_o);
endmodule

// File: rtl/z80_mem_overlay.sv
module z80_mem_overlay #(
  parameter int MEM_AW = 16,
  parameter int ROM_AW = 12,
  parameter int WIN_AW = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mreq_ni,
  input  logic [MEM_AW-1:0] addr_i,
  input  logic              rom_dis_i,
  output logic              rom_cs_o,
  output logic [ROM_AW-1:0] rom_addr_o,
  output logic              dram_cs_o
);
  logic in_window;
  logic unused_mid;

  assign in_window  = ~|addr_i[MEM_AW-1:WIN_AW];
  assign unused_mid = ^addr_i[WIN_AW-1:ROM_AW]; // mirror bits, ignored
  assign rom_cs_o   = !mreq_ni && in_window && !rom_dis_i;
  assign dram_cs_o  = !mreq_ni && !rom_cs_o;
  assign rom_addr_o = addr_i[ROM_AW-1:0];

  p_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rom_cs_o && dram_cs_o));
  p_high_dram_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mreq_ni && addr_i[MEM_AW-1]) |-> (dram_cs_o && !rom_cs_o));
  p_disabled_dram_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mreq_ni && rom_dis_i) |-> dram_cs_o);
endmodule

// File: rtl/z80_io_glue.sv
module z80_io_glue
  import z80_glue_pkg::*;
#(
  parameter int IO_AW  = 8,
  parameter int DATA_W = 8,
  parameter int MEM_AW = 16,
  parameter int ROM_AW = 12,
  parameter int WIN_AW = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IO_AW-1:0]  io_addr_i,
  input  logic              iorq_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic              m1_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              mreq_ni,
  input  logic [MEM_AW-1:0] mem_addr_i,
  output logic              ctc_cs_o,
  output logic [1:0]        ctc_ch_o,
  output logic              sio_cs_o,
  output logic              sio_ch_o,
  output logic              sio_cd_o,
  output logic              fdc_cs_o,
  output logic [1:0]        fdc_rs_o,
  output logic              fdc_rd_o,
  output logic              fdc_wr_o,
  output logic              user_cs_o,
  output logic [DRV_W-1:0]  drv_sel_o,
  output logic              side1_o,
  output logic              dden_dis_o,
  output logic              rom_dis_o,
  output logic [DATA_W-1:0] prn_data_o,
  output logic              prn_strobe_o,
  output logic              rom_cs_o,
  output logic [ROM_AW-1:0] rom_addr_o,
  output logic              dram_cs_o
);
  io_class_e         io_class;
  logic              reg_wr;
  logic [CTRL_W-1:0] ctrl;

  z80_io_decode #(.IO_AW(IO_AW)) u_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (io_addr_i),
    .iorq_ni  (iorq_ni),
    .rd_ni    (rd_ni),
    .wr_ni    (wr_ni),
    .m1_ni    (m1_ni),
    .class_o  (io_class),
    .reg_wr_o (reg_wr),
    .ctc_cs_o (ctc_cs_o),
    .ctc_ch_o (ctc_ch_o),
    .sio_cs_o (sio_cs_o),
    .sio_ch_o (sio_ch_o),
    .sio_cd_o (sio_cd_o),
    .fdc_cs_o (fdc_cs_o),
    .fdc_rs_o (fdc_rs_o),
    .fdc_rd_o (fdc_rd_o),
    .fdc_wr_o (fdc_wr_o),
    .user_cs_o(user_cs_o)
  );

  z80_board_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .class_i     (io_class),
    .reg_wr_i    (reg_wr),
    .data_i      (data_i),
    .ctrl_o      (ctrl),
    .prn_data_o  (prn_data_o),
    .prn_strobe_o(prn_strobe_o)
  );

  assign rom_dis_o  = ctrl[BIT_ROM_DIS];
  assign dden_dis_o = ctrl[BIT_DDEN];
  assign side1_o    = ctrl[BIT_SIDE];
  assign drv_sel_o  = ctrl[DRV_W-1:0];

  z80_mem_overlay #(.MEM_AW(MEM_AW), .ROM_AW(ROM_AW), .WIN_AW(WIN_AW)) u_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mreq_ni   (mreq_ni),
    .addr_i    (mem_addr_i),
    .rom_dis_i (rom_dis_o),
    .rom_cs_o  (rom_cs_o),
    .rom_addr_o(rom_addr_o),
    .dram_cs_o (dram_cs_o)
  );
endmodule

// File: tb/tb_z80_io_glue.sv
`timescale 1ns/1ps
module tb_z80_io_glue;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]  io_addr = '0;
  logic iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, m1_n = 1'b1, mreq_n = 1'b1;
  logic [7:0]  data = '0;
  logic [15:0] mem_addr = '0;

  logic ctc_cs, sio_cs, sio_ch, sio_cd, fdc_cs, fdc_rd, fdc_wr, user_cs;
  logic [1:0] ctc_ch, fdc_rs;
  logic [3:0] drv_sel;
  logic side1, dden_dis, rom_dis, prn_strobe, rom_cs, dram_cs;
  logic [7:0] prn_data;
  logic [11:0] rom_addr;

  int checks = 0, failures = 0;
  bit done = 0;
  int ref_ctrl = 0, ref_prn = 0, ref_stb = 0;

  always #4 clk = ~clk;

  z80_io_glue dut (
    .clk_i(clk), .rst_ni(rst_n), .io_addr_i(io_addr), .iorq_ni(iorq_n),
    .rd_ni(rd_n), .wr_ni(wr_n), .m1_ni(m1_n), .data_i(data),
    .mreq_ni(mreq_n), .mem_addr_i(mem_addr),
    .ctc_cs_o(ctc_cs), .ctc_ch_o(ctc_ch), .sio_cs_o(sio_cs), .sio_ch_o(sio_ch),
    .sio_cd_o(sio_cd), .fdc_cs_o(fdc_cs), .fdc_rs_o(fdc_rs), .fdc_rd_o(fdc_rd),
    .fdc_wr_o(fdc_wr), .user_cs_o(user_cs), .drv_sel_o(drv_sel), .side1_o(side1),
    .dden_dis_o(dden_dis), .rom_dis_o(rom_dis), .prn_data_o(prn_data),
    .prn_strobe_o(prn_strobe), .rom_cs_o(rom_cs), .rom_addr_o(rom_addr),
    .dram_cs_o(dram_cs)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s io=%02h mem=%04h act=%0h exp=%0h", tag, what, io_addr,
               mem_addr, act, exp);
    end
  endtask

  // Reference model: outputs from current inputs and model state
  task automatic compare();
    bit act_io, inta, e_ctc, e_sio, e_fdc, e_usr, low, e_rom;
    int a, m;
    a = io_addr; m = mem_addr;
    act_io = !iorq_n && m1_n;
    inta   = !iorq_n && !m1_n;
    e_ctc = act_io && (a / 64 == 1);
    e_sio = act_io && (a / 64 == 2);
    e_fdc = act_io && (a / 64 == 3);
    e_usr = act_io && (a / 16 == 3);
    chk("R4", {ctc_cs, ctc_ch}, {e_ctc, e_ctc ? 2'((a / 16) % 4) : 2'b00}, "ctc");
    chk("R5", {sio_cs, sio_ch, sio_cd},
        {e_sio, e_sio && ((a / 8) % 2 == 1), e_sio && ((a / 4) % 2 == 1)}, "sio");
    chk("R6", {fdc_cs, fdc_rs, fdc_rd, fdc_wr},
        {e_fdc, e_fdc ? 2'(a % 4) : 2'b00, e_fdc && !rd_n, e_fdc && !wr_n}, "fdc");
    chk("R7", user_cs, e_usr, "user");
    if (inta)
      chk("R8", {ctc_cs, sio_cs, fdc_cs, user_cs}, 0, "inta select");
    chk("R1", {rom_dis, dden_dis, side1, drv_sel}, ref_ctrl, "ctrl");
    chk("R11", rom_dis, (ref_ctrl / 64) % 2, "rom_dis field");
    chk("R11", drv_sel, ref_ctrl % 16, "drive field");
    chk("R2", prn_data, ref_prn, "printer data");
    chk("R3", prn_strobe, ref_stb, "strobe");
    low   = m < 32768;
    e_rom = !mreq_n && low && ((ref_ctrl / 64) % 2 == 0);
    if (low) chk("R9", {rom_cs, dram_cs, rom_addr}, {e_rom, !mreq_n && !e_rom, 12'(m % 4096)}, "low mem");
    else     chk("R10", {rom_cs, dram_cs, rom_addr}, {1'b0, !mreq_n, 12'(m % 4096)}, "high mem");
  endtask

  task automatic update();
    int a;
    a = io_addr;
    if (rst_n && !iorq_n && m1_n && !wr_n && a < 32) begin
      case (a % 4)
        0: ref_ctrl = data % 128;
        1: ref_prn  = data;
        2: ref_stb  = 1;
        default: ref_stb = 0;
      endcase
    end
  endtask

  task automatic io_cyc(input logic [7:0] a, input logic [7:0] d, input bit rd,
                        input bit wr, input bit m1);
    @(negedge clk);
    io_addr = a; data = d; iorq_n = 1'b0; rd_n = !rd; wr_n = !wr; m1_n = !m1;
    mreq_n = 1'b1;
    #1 compare();
    @(posedge clk);
    update();
  endtask

  task automatic mem_cyc(input logic [15:0] ma);
    @(negedge clk);
    mem_addr = ma; mreq_n = 1'b0; iorq_n = 1'b1; rd_n = 1'b0; wr_n = 1'b1; m1_n = 1'b1;
    #1 compare();
    @(posedge clk);
    update();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #2 compare();                           // reset state R1 R2 R3
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 aliases, R11 fields
    io_cyc(8'h00, 8'h45, 0, 1, 0);
    io_cyc(8'h1C, 8'hFF, 0, 1, 0);
    io_cyc(8'h10, 8'h00, 1, 0, 0);          // read leaves it unchanged
    io_cyc(8'h04, 8'h2A, 0, 1, 0);
    // R2
    io_cyc(8'h01, 8'hA5, 0, 1, 0);
    io_cyc(8'h19, 8'h3C, 0, 1, 0);
    // R3 strobe, data ignored
    io_cyc(8'h02, 8'h00, 0, 1, 0);
    io_cyc(8'h02, 8'hFF, 0, 1, 0);
    io_cyc(8'h1F, 8'hFF, 0, 1, 0);
    io_cyc(8'h0E, 8'h55, 0, 1, 0);
    io_cyc(8'h13, 8'h00, 0, 1, 0);
    // R7 reserved range writes nothing
    io_cyc(8'h20, 8'h7F, 0, 1, 0);
    io_cyc(8'h2E, 8'h7F, 0, 1, 0);
    // decode sweeps: reads, writes, interrupt acknowledge (R8)
    for (int i = 0; i < 256; i++) io_cyc(8'(i), 8'(255 - i), 1, 0, 0);
    for (int i = 0; i < 256; i++) io_cyc(8'(i), 8'(i * 7), 0, 1, 0);
    for (int i = 0; i < 256; i++) io_cyc(8'(i), 8'(i ^ 8'h5A), 0, 1, 1);
    for (int i = 0; i < 256; i++) io_cyc(8'(i), 8'h00, 1, 0, 1);
    // R9 R10 ROM enabled then disabled
    for (int pass = 0; pass < 2; pass++) begin
      io_cyc(8'h08, pass ? 8'h40 : 8'h00, 0, 1, 0);
      mem_cyc(16'h0000); mem_cyc(16'h0FFF); mem_cyc(16'h1000);
      mem_cyc(16'h7FFF); mem_cyc(16'h8000); mem_cyc(16'hFFFF);
      for (int k = 0; k < 256; k++) mem_cyc(16'(k * 257 + 3));
      @(negedge clk); mreq_n = 1'b1; mem_addr = 16'h0123; #1 compare();
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule